// File: doc/BRIEF.md
# System Clock Control Unit

This block holds the one-byte clock configuration register of a small microcontroller and turns it into the signals that steer the clock tree. It decodes the register's special-function address on a simple read/write bus. It drives the enables for the internal RC oscillator and the crystal oscillator, selects the system clock source, and selects the prescaler ratio for the internal RC clock. It also reports which stop-mode type the next stop uses. The oscillators, the glitch-free clock multiplexer and the divider itself sit outside the block.

A software-bypass bit decides when a new setting becomes active. With the bypass bit set, every register write applies its source, divider and oscillator settings on the same clock edge. With the bypass bit clear, the written values stay pending in the register, and the active set loads from them only when the CPU wakes up from a stop. A fuse input can force the crystal off at any time. A one-cycle pulse marks every change of the effective source or divider.

Top module: `sysclk_ctrl`

## Requirements
- R1: After reset the register reads 0x04. The source select is 00, the divider select is 00, the RC enable is 1, the crystal enable is 0 and the switch pulse is 0.
- R2: The register is read and written only at address 0x8A. Its bits, from bit 7 down to bit 0, are: stop-type, divider[1:0], bypass, RC-off, crystal-off, source[1:0]. A write to any other address changes nothing. A read at any other address returns 0x00.
- R3: With the bypass bit clear, a write leaves the active outputs unchanged. The pending values become active on the clock edge that samples a wake-up pulse during a stop.
- R4: A write whose bypass bit is 1 applies its source, divider and oscillator-off values on the write's own clock edge.
- R5: The divider select equals the active divider field (00 = /1, 01 = /2, 10 = /4, 11 = /8) only while the active source is the internal RC (source 00). While the crystal (source 01) is active it is 00.
- R6: The RC enable and the crystal enable are the inverses of the active RC-off and crystal-off bits. In hardware mode they change only at wake-up.
- R7: While the fuse input is 0, the crystal-off bit reads as 1 and the crystal enable is 0. A write made while the fuse is 0 stores crystal-off as 1.
- R8: Source codes 10 and 11 are reserved. Loading one of them leaves the active source unchanged.
- R9: The switch pulse is high for exactly the one cycle after an edge that changes the active source or the effective divider select. It is never high otherwise.
- R10: On a stop entry with the full-stop command, the stop-type output takes the stop-type bit. With the light command it is 0. It is 0 whenever no stop is in progress.
- R11: A wake-up pulse while no stop is in progress is ignored.
- R12: A write that clears the bypass bit keeps all other written bits as given and leaves the active outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Special-function address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational, 0 when not selected) |
| stop_req | input | 1 | One-cycle stop entry pulse |
| stop_full | input | 1 | 1 when the stop command is the full-stop command |
| wake_up | input | 1 | One-cycle wake-up pulse |
| xtal_fuse | input | 1 | Crystal permitted when 1 |
| irc_en | output | 1 | Internal RC oscillator enable |
| xtal_en | output | 1 | Crystal oscillator enable |
| clk_src | output | 2 | Active system clock source |
| div_sel | output | 2 | Effective RC prescaler select |
| stop_active | output | 1 | A stop is in progress |
| stop1_sel | output | 1 | Stop type of the current stop |
| switch_pulse | output | 1 | One-cycle pulse after an effective clock change |

## Verification
A wrong active state shows directly on clk_src, div_sel and the two enables in the cycle after the edge that should, or should not, have loaded it. A stale pending register shows at the next wake-up or at the next read of 0x8A. A misplaced or missing load event also shows as a switch pulse out of place. That error is visible one cycle after the offending edge, so every check samples just after a single edge and compares both the outputs and the pulse.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;

  typedef struct packed {
    logic       stop1;
    logic [1:0] div;
    logic       byp;
    logic       istop;
    logic       xstop;
    logic [1:0] cs;
  } sccfg_t;

  localparam logic [1:0] SRC_IRC  = 2'b00;
  localparam logic [1:0] SRC_XTAL = 2'b01;

  // Source codes with bit 1 set are reserved.
  function automatic logic src_legal(input logic [1:0] cs);
    return (cs == SRC_IRC) || (cs == SRC_XTAL);
  endfunction

  // The divider select reaches the clock tree only while the RC clock is the source.
  function automatic logic [1:0] eff_div(input logic [1:0] src, input logic [1:0] div);
    return (src == SRC_IRC) ? div : 2'b00;
  endfunction

  // A write made while the crystal fuse is 0 stores the crystal-off bit as 1.
  function automatic sccfg_t fuse_mask(input sccfg_t c, input logic fuse);
    sccfg_t r;
    r       = c;
    r.xstop = c.xstop | ~fuse;
    return r;
  endfunction

endpackage

// File: rtl/sysclk_regfile.sv
module sysclk_regfile
  import sysclk_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h8A,
  parameter logic [7:0]  RST_VAL  = 8'h04
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              xtal_fuse,
  output logic [7:0]        bus_rdata,
  output logic              wr_hit,
  output sccfg_t            wr_cfg,
  output sccfg_t            pend_cfg
);

  logic   sel;
  sccfg_t view;

  assign sel    = (bus_addr == CFG_ADDR);
  assign wr_hit = bus_wr && sel;
  assign wr_cfg = fuse_mask(sccfg_t'(bus_wdata), xtal_fuse);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_cfg <= sccfg_t'(RST_VAL);
    else if (wr_hit)  pend_cfg <= wr_cfg;
  end

  assign view      = fuse_mask(pend_cfg, xtal_fuse);
  assign bus_rdata = (bus_rd && sel) ? view : 8'h00;

  // R2: a write elsewhere leaves the stored byte alone
  a_r2_foreign_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !sel) |=> $stable(pend_cfg));

  // R7: the crystal-off bit reads back as 1 while the fuse is 0
  a_r7_fuse_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && sel && !xtal_fuse) |-> bus_rdata[2]);

endmodule

// File: rtl/sysclk_stopctl.sv
module sysclk_stopctl (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_req,
  input  logic stop_full,
  input  logic wake_up,
  input  logic stop1_bit,
  output logic stop_active,
  output logic stop1_sel,
  output logic wake_ev
);

  assign wake_ev = wake_up && stop_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_active <= 1'b0;
      stop1_sel   <= 1'b0;
    end else if (stop_req && !stop_active) begin
      stop_active <= 1'b1;
      stop1_sel   <= stop_full && stop1_bit;
    end else if (wake_ev) begin
      stop_active <= 1'b0;
      stop1_sel   <= 1'b0;
    end
  end

  // R11: a wake-up without a stop in progress is ignored
  a_r11_stray_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_up && !stop_active && !stop_req) |=> !stop_active);

  // R10: the stop type is only reported during a stop
  a_r10_type_in_stop: assert property (@(posedge clk) disable iff (!rst_n)
    stop1_sel |-> stop_active);

endmodule

// File: rtl/sysclk_seq.sv
module sysclk_seq
  import sysclk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_hit,
  input  sccfg_t     wr_cfg,
  input  sccfg_t     pend_cfg,
  input  logic       wake_ev,
  input  logic       xtal_fuse,
  output logic [1:0] clk_src,
  output logic [1:0] div_sel,
  output logic       irc_en,
  output logic       xtal_en,
  output logic       switch_pulse
);

  logic       sw_load, hw_load, load_ev;
  sccfg_t     src_cfg;
  logic [1:0] act_cs, act_div, nxt_cs, nxt_div;
  logic       act_istop, act_xstop;

  assign sw_load = wr_hit && wr_cfg.byp;
  assign hw_load = wake_ev && !pend_cfg.byp;
  assign load_ev = sw_load || hw_load;
  assign src_cfg = sw_load ? wr_cfg : pend_cfg;

  always_comb begin
    nxt_cs  = act_cs;
    nxt_div = act_div;
    if (load_ev) begin
      if (src_legal(src_cfg.cs)) nxt_cs = src_cfg.cs;
      nxt_div = src_cfg.div;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_cs       <= SRC_IRC;
      act_div      <= 2'b00;
      act_istop    <= 1'b0;
      act_xstop    <= 1'b1;
      switch_pulse <= 1'b0;
    end else begin
      act_cs       <= nxt_cs;
      act_div      <= nxt_div;
      switch_pulse <= (nxt_cs != act_cs) ||
                      (eff_div(nxt_cs, nxt_div) != eff_div(act_cs, act_div));
      if (load_ev) begin
        act_istop <= src_cfg.istop;
        act_xstop <= src_cfg.xstop;
      end
    end
  end

  assign clk_src = act_cs;
  assign div_sel = eff_div(act_cs, act_div);
  assign irc_en  = ~act_istop;
  assign xtal_en = ~act_xstop & xtal_fuse;

  // R3: without a load event the active source holds
  a_r3_hold_without_load: assert property (@(posedge clk) disable iff (!rst_n)
    !load_ev |=> $stable(act_cs));

  // R8: a reserved source code never becomes active
  a_r8_reserved_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (load_ev && src_cfg.cs[1]) |=> $stable(act_cs));

  // R9: a pulse always follows a real change of source or divider
  a_r9_pulse_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    switch_pulse |-> (clk_src != $past(clk_src)) || (div_sel != $past(div_sel)));

  // R7: the crystal stays off while its fuse is 0
  a_r7_fuse_blocks_xtal: assert property (@(posedge clk) disable iff (!rst_n)
    !xtal_fuse |-> !xtal_en);

endmodule

// File: rtl/sysclk_ctrl.sv
module sysclk_ctrl
  import sysclk_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h8A,
  parameter logic [7:0]        RST_VAL  = 8'h04
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              stop_req,
  input  logic              stop_full,
  input  logic              wake_up,
  input  logic              xtal_fuse,
  output logic              irc_en,
  output logic              xtal_en,
  output logic [1:0]        clk_src,
  output logic [1:0]        div_sel,
  output logic              stop_active,
  output logic              stop1_sel,
  output logic              switch_pulse
);

  logic   wr_hit, wake_ev;
  sccfg_t wr_cfg, pend_cfg;

  sysclk_regfile #(.ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR), .RST_VAL(RST_VAL)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .xtal_fuse(xtal_fuse),
    .bus_rdata(bus_rdata), .wr_hit(wr_hit), .wr_cfg(wr_cfg), .pend_cfg(pend_cfg)
  );

  sysclk_stopctl u_stop (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .stop_full(stop_full),
    .wake_up(wake_up), .stop1_bit(pend_cfg.stop1),
    .stop_active(stop_active), .stop1_sel(stop1_sel), .wake_ev(wake_ev)
  );

  sysclk_seq u_seq (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .wr_cfg(wr_cfg),
    .pend_cfg(pend_cfg), .wake_ev(wake_ev), .xtal_fuse(xtal_fuse),
    .clk_src(clk_src), .div_sel(div_sel), .irc_en(irc_en),
    .xtal_en(xtal_en), .switch_pulse(switch_pulse)
  );

  // R12: a write that clears the bypass bit leaves the active source alone
  a_r12_clear_bypass_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !bus_wdata[4] && !wake_ev) |=> $stable(clk_src));

endmodule

// File: tb/sysclk_ctrl_bench.sv
module sysclk_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       stop_req = 1'b0, stop_full = 1'b0, wake_up = 1'b0, xtal_fuse = 1'b1;
  logic       irc_en, xtal_en, stop_active, stop1_sel, switch_pulse;
  logic [1:0] clk_src, div_sel;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  localparam logic [7:0] REG_A = 8'h8A;

  always #2 clk = ~clk;

  sysclk_ctrl u_sysclk_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .stop_req(stop_req), .stop_full(stop_full), .wake_up(wake_up),
    .xtal_fuse(xtal_fuse), .irc_en(irc_en), .xtal_en(xtal_en),
    .clk_src(clk_src), .div_sel(div_sel), .stop_active(stop_active),
    .stop1_sel(stop1_sel), .switch_pulse(switch_pulse)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Outputs after one edge: {src, div, irc_en, xtal_en}, sampled at the negedge.
  task automatic chk_out(input string req, input logic [1:0] s, input logic [1:0] d,
                         input logic ie, input logic xe);
    chk(req, {clk_src, div_sel, irc_en, xtal_en}, {s, d, ie, xe});
  endtask

  task automatic write_at(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic read_at(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic stop_in(input logic full);
    @(negedge clk);
    stop_req = 1'b1; stop_full = full;
    @(negedge clk);
    stop_req = 1'b0;
  endtask

  task automatic wake;
    @(negedge clk);
    wake_up = 1'b1;
    @(negedge clk);
    wake_up = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] r;
    read_at(REG_A, r);
    chk("R1 reset value", r, 8'h04);
    chk_out("R1 reset outputs", 2'b00, 2'b00, 1'b1, 1'b0);
    chk("R1 reset pulse", switch_pulse, 0);
  endtask

  task automatic t_bypass;
    logic [7:0] r;
    write_at(REG_A, 8'h11);
    chk_out("R4 bypass to crystal", 2'b01, 2'b00, 1'b1, 1'b1);
    chk("R9 pulse on source change", switch_pulse, 1);
    @(negedge clk);
    chk("R9 pulse lasts one cycle", switch_pulse, 0);
    read_at(REG_A, r);
    chk("R2 readback", r, 8'h11);
  endtask

  task automatic t_divider;
    write_at(REG_A, 8'h50);
    chk_out("R5 RC div4", 2'b00, 2'b10, 1'b1, 1'b1);
    chk("R9 pulse back to RC", switch_pulse, 1);
    write_at(REG_A, 8'h70);
    chk_out("R5 RC div8", 2'b00, 2'b11, 1'b1, 1'b1);
    chk("R9 pulse on divider", switch_pulse, 1);
    write_at(REG_A, 8'h71);
    chk_out("R5 crystal hides divider", 2'b01, 2'b00, 1'b1, 1'b1);
    write_at(REG_A, 8'h31);
    chk_out("R5 crystal div change hidden", 2'b01, 2'b00, 1'b1, 1'b1);
    chk("R9 no pulse without effective change", switch_pulse, 0);
  endtask

  task automatic t_clear_bypass;
    logic [7:0] r;
    write_at(REG_A, 8'h21);
    chk_out("R12 outputs hold", 2'b01, 2'b00, 1'b1, 1'b1);
    chk("R12 no pulse", switch_pulse, 0);
    read_at(REG_A, r);
    chk("R12 other bits kept", r, 8'h21);
  endtask

  task automatic t_hardware;
    write_at(REG_A, 8'h20);
    chk_out("R3 write held", 2'b01, 2'b00, 1'b1, 1'b1);
    wake;
    chk_out("R11 stray wake ignored", 2'b01, 2'b00, 1'b1, 1'b1);
    chk("R11 no stop", stop_active, 0);
    stop_in(1'b1);
    chk("R10 stop entered", stop_active, 1);
    chk("R10 stop2 type", stop1_sel, 0);
    chk_out("R3 held during stop", 2'b01, 2'b00, 1'b1, 1'b1);
    wake;
    chk_out("R3 applied at wake", 2'b00, 2'b01, 1'b1, 1'b1);
    chk("R9 pulse at wake", switch_pulse, 1);
    chk("R3 stop left", stop_active, 0);
  endtask

  task automatic t_stop_type;
    write_at(REG_A, 8'hA0);
    chk("R9 no pulse same values", switch_pulse, 0);
    stop_in(1'b1);
    chk("R10 stop1 type full cmd", stop1_sel, 1);
    wake;
    chk("R10 type cleared", stop1_sel, 0);
    stop_in(1'b0);
    chk("R10 light cmd type", stop1_sel, 0);
    wake;
  endtask

  task automatic t_osc;
    write_at(REG_A, 8'h28);
    chk_out("R6 rc-off held in hw mode", 2'b00, 2'b01, 1'b1, 1'b1);
    stop_in(1'b0);
    wake;
    chk_out("R6 rc-off at wake", 2'b00, 2'b01, 1'b0, 1'b1);
    write_at(REG_A, 8'h14);
    chk_out("R6 bypass enables", 2'b00, 2'b00, 1'b1, 1'b0);
    chk("R9 pulse div to 1", switch_pulse, 1);
  endtask

  task automatic t_reserved;
    write_at(REG_A, 8'h12);
    chk_out("R8 code 10 ignored", 2'b00, 2'b00, 1'b1, 1'b1);
    chk("R8 no pulse", switch_pulse, 0);
    write_at(REG_A, 8'h13);
    chk_out("R8 code 11 ignored", 2'b00, 2'b00, 1'b1, 1'b1);
  endtask

  task automatic t_address;
    logic [7:0] r;
    write_at(8'h8B, 8'hFF);
    chk_out("R2 foreign write no effect", 2'b00, 2'b00, 1'b1, 1'b1);
    read_at(REG_A, r);
    chk("R2 register unchanged", r, 8'h13);
    read_at(8'h8B, r);
    chk("R2 foreign read zero", r, 8'h00);
  endtask

  task automatic t_fuse;
    logic [7:0] r;
    xtal_fuse = 1'b0;
    #1;
    chk("R7 crystal off by fuse", xtal_en, 0);
    read_at(REG_A, r);
    chk("R7 readback forced", r, 8'h17);
    write_at(REG_A, 8'h11);
    chk("R7 crystal stays off", xtal_en, 0);
    xtal_fuse = 1'b1;
    read_at(REG_A, r);
    chk("R7 stored forced", r, 8'h15);
    chk("R7 enable after fuse", xtal_en, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bypass();
    t_divider();
    t_clear_bypass();
    t_hardware();
    t_stop_type();
    t_osc();
    t_reserved();
    t_address();
    t_fuse();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule